// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block links two 18-bit ports, A and B, and carries data in both directions at once. Each direction has its own row of per-bit storage and its own four controls: an active-low output enable, an active-low clock enable, a latch enable that is active high, and a data clock. Depending on those controls, the storage passes data straight through, keeps what it holds, or takes a new value on a rising edge of the data clock.

The physical pins are split into separate input, output and drive-enable vectors, so the block can be synthesized and tested. The B side acts as an open-drain driver. It pulls a line low only for a stored 0 and releases it for a stored 1, so other agents can wire-OR onto the same line. The A side is an ordinary three-state driver. The block runs on a fast sampling clock. The data clocks and latch enables are sampled levels, and each direction follows a small state machine whose state is the pair (latch enable, data clock) seen at the last sample.

The four states of each direction are ST_FLOW_LO, ST_FLOW_HI, ST_KEEP_LO and ST_KEEP_HI. FLOW means the latch enable was high, KEEP means it was low, and LO or HI gives the last sampled level of the data clock. On every sample the state moves to the pair that is now present. A capture is possible only when leaving a LO state while the data clock reads high. Reset puts both directions in ST_KEEP_HI, so the first clock level cannot fake an edge.

Top module: `bus_xcvr18`

## Requirements
- R1: An asynchronous active-low reset sets every storage bit of both directions to 1. After reset, with the latch enables low, a_out and b_out read all ones, and b_drv reads zero.
- R2: While a direction's output enable is 1, every drive-enable bit of that direction's output is 0, and the output value still shows the stored data.
- R3: While a direction's latch enable is 1, its output equals its input in the same cycle. It follows every change without waiting for a sample.
- R4: When the latch enable is 0 and the clock enable is 0, a data clock that was sampled low and is then sampled high loads the input present at that sample. The new value appears at the output after that sampling edge and not before.
- R5: When the latch enable is 0 and no low-to-high data clock change is sampled, the stored value and the output do not change, even if the input changes. This includes a data clock held high.
- R6: When the clock enable is 1 and the latch enable is 0, a low-to-high data clock change loads nothing.
- R7: A fall of the latch enable while the data clock is high keeps the last value that was passed through. A fall while the data clock is low keeps that value until the next rising data clock, which then loads new data.
- R8: B-side drive-enable bit i is 1 exactly when the A-to-B output enable is 0 and stored bit i is 0. b_out carries the stored value.
- R9: A-side drive-enable is all ones while the B-to-A output enable is 0, and a_out carries the B-to-A stored value.
- R10: The two directions are independent. Activity on one set of controls leaves the other direction's output unchanged.
- R11: If the latch enable falls in the same sample in which the data clock rises from low, with the clock enable at 0, the input of that sample is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Levels seen on the A pins |
| a_out | output | 18 | Value for the A pins (B-to-A data) |
| a_drv | output | 18 | Per-bit drive enable of the A pins |
| b_in | input | 18 | Levels seen on the B pins |
| b_out | output | 18 | A-to-B data value |
| b_drv | output | 18 | Per-bit pull-low enable of the B pins |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_clk | input | 1 | A-to-B data clock (sampled level) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_clk | input | 1 | B-to-A data clock (sampled level) |

## Verification
Two functions can land in the same sample: the fall of the latch enable, which ends transparency, and a rising data clock, which starts a capture. The bench provokes this by moving from ST_FLOW_LO with the latch enable dropped, the data clock raised and the input changed, all in one sample. It expects the new input, not the last value that passed through. The nearby cases are judged as well: the latch enable falling with the data clock already high must hold the old value, and a rising edge with the clock enable high must load nothing.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    // {latch enable seen, data clock seen} at the last sample
    typedef enum logic [1:0] {
        ST_KEEP_LO = 2'b00,
        ST_KEEP_HI = 2'b01,
        ST_FLOW_LO = 2'b10,
        ST_FLOW_HI = 2'b11
    } lane_st_e;

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import bus_xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic         le,
    input  logic         ce_n,
    input  logic         dclk,
    output logic [W-1:0] q
);

    lane_st_e     st_q, st_d;
    logic [W-1:0] store_q;
    logic         rise_seen;
    logic         load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_KEEP_HI;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and capture decision
    always_comb begin
        rise_seen = 1'b0;
        unique case (st_q)
            ST_KEEP_LO, ST_FLOW_LO: rise_seen = dclk;
            ST_KEEP_HI, ST_FLOW_HI: rise_seen = 1'b0;
            default:                rise_seen = 1'b0;
        endcase
        load = le | (rise_seen & ~ce_n);
        if (le) begin
            st_d = dclk ? ST_FLOW_HI : ST_FLOW_LO;
        end else begin
            st_d = dclk ? ST_KEEP_HI : ST_KEEP_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '1;
        end else if (load) begin
            store_q <= d_in;
        end
    end

    // output: pass-through while transparent, otherwise the stored word
    always_comb begin
        q = le ? d_in : store_q;
    end

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ce_n && dclk && (st_q == ST_KEEP_LO || st_q == ST_FLOW_LO))
        |=> (store_q == $past(d_in)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !dclk) |=> $stable(store_q));

    // R6
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ce_n) |=> $stable(store_q));

    // R7
    fall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && dclk && st_q == ST_FLOW_HI) |=> $stable(store_q));

    // R3
    flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (store_q == $past(d_in)));

endmodule

// File: rtl/xcvr_drv.sv
module xcvr_drv #(
    parameter int W          = 18,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic [W-1:0] val,
    input  logic         oe_n,
    output logic [W-1:0] out,
    output logic [W-1:0] drv
);

    assign out = val;

    generate
        if (OPEN_DRAIN) begin : g_od
            // pull low only for a 0, release for a 1
            assign drv = oe_n ? '0 : ~val;
        end else begin : g_tri
            assign drv = {W{~oe_n}};
        end
    endgenerate

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    input  logic         ab_oe_n,
    input  logic         ab_ce_n,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ba_oe_n,
    input  logic         ba_ce_n,
    input  logic         ba_le,
    input  logic         ba_clk
);

    logic [W-1:0] ab_val;
    logic [W-1:0] ba_val;

    xcvr_lane #(.W(W)) u_ab_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (a_in),
        .le   (ab_le),
        .ce_n (ab_ce_n),
        .dclk (ab_clk),
        .q    (ab_val)
    );

    xcvr_lane #(.W(W)) u_ba_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (b_in),
        .le   (ba_le),
        .ce_n (ba_ce_n),
        .dclk (ba_clk),
        .q    (ba_val)
    );

    xcvr_drv #(.W(W), .OPEN_DRAIN(1'b1)) u_b_drv (
        .val (ab_val),
        .oe_n(ab_oe_n),
        .out (b_out),
        .drv (b_drv)
    );

    xcvr_drv #(.W(W), .OPEN_DRAIN(1'b0)) u_a_drv (
        .val (ba_val),
        .oe_n(ba_oe_n),
        .out (a_out),
        .drv (a_drv)
    );

    // R2
    b_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> (b_drv == '0));

    // R2
    a_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> (a_drv == '0));

    // R8
    b_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe_n |-> (((b_drv & b_out) == '0) && ((b_drv | b_out) == '1)));

    // R9
    a_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe_n |-> (a_drv == '1));

    // R10
    ab_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_ce_n) |=> $stable(b_out) || $past(ab_le) != ab_le);

endmodule

// File: tb/bus_xcvr18_tb.sv
module bus_xcvr18_tb;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, a_drv, b_out, b_drv;
    logic         ab_oe_n = 1'b0, ab_ce_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b1;
    logic         ba_oe_n = 1'b0, ba_ce_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_xcvr18 #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_oe_n(ab_oe_n), .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_clk(ba_clk)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ab_set(input logic le, input logic ce_n, input logic dc, input logic [W-1:0] d);
        @(negedge clk);
        ab_le = le; ab_ce_n = ce_n; ab_clk = dc; a_in = d;
    endtask

    task automatic ba_set(input logic le, input logic ce_n, input logic dc, input logic [W-1:0] d);
        @(negedge clk);
        ba_le = le; ba_ce_n = ce_n; ba_clk = dc; b_in = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 b_out", b_out, '1);
        chk("R1 b_drv", b_drv, '0);
        chk("R1 a_out", a_out, '1);
        chk("R9 a_drv", a_drv, '1);
    endtask

    task automatic t_transparent();
        ab_set(1, 1, 0, 18'h2A5C3);
        #1;
        chk("R3 pass", b_out, 18'h2A5C3);
        chk("R8 pull", b_drv, ~18'h2A5C3);
        a_in = 18'h15A3C;
        #1;
        chk("R3 follow", b_out, 18'h15A3C);
    endtask

    task automatic t_fall_clk_high();
        ab_set(1, 0, 1, 18'h0F0F1);
        tick();
        ab_set(0, 0, 1, 18'h3C3C3);
        #1;
        chk("R7 fall high", b_out, 18'h0F0F1);
        tick();
        chk("R7 fall high kept", b_out, 18'h0F0F1);
        tick();
        chk("R5 clock held high", b_out, 18'h0F0F1);
    endtask

    task automatic t_capture();
        ab_set(0, 0, 0, 18'h12345);
        tick();
        chk("R5 clock low", b_out, 18'h0F0F1);
        ab_set(0, 0, 1, 18'h2ABCD);
        #1;
        chk("R4 before edge", b_out, 18'h0F0F1);
        tick();
        chk("R4 captured", b_out, 18'h2ABCD);
    endtask

    task automatic t_fall_clk_low();
        ab_set(1, 0, 0, 18'h01234);
        tick();
        ab_set(0, 0, 0, 18'h3FFF0);
        tick();
        chk("R7 fall low held", b_out, 18'h01234);
        ab_set(0, 0, 1, 18'h3FFF0);
        tick();
        chk("R7 fall low then edge", b_out, 18'h3FFF0);
    endtask

    task automatic t_inhibit();
        ab_set(0, 1, 0, 18'h00A0A);
        tick();
        ab_set(0, 1, 1, 18'h00A0A);
        tick();
        chk("R6 inhibit", b_out, 18'h3FFF0);
    endtask

    task automatic t_simul();
        ab_set(1, 0, 0, 18'h11111);
        tick();
        ab_set(0, 0, 1, 18'h22222);
        tick();
        chk("R11 same sample", b_out, 18'h22222);
        chk("R8 pull after capture", b_drv, ~18'h22222);
    endtask

    task automatic t_oe();
        @(negedge clk);
        ab_oe_n = 1'b1;
        #1;
        chk("R2 b released", b_drv, '0);
        chk("R2 b value kept", b_out, 18'h22222);
        @(negedge clk);
        ab_oe_n = 1'b0;
        #1;
        chk("R8 pull restored", b_drv, ~18'h22222);
    endtask

    task automatic t_ba();
        ba_set(1, 1, 0, 18'h0AAAA);
        #1;
        chk("R3 ba pass", a_out, 18'h0AAAA);
        chk("R9 a driven", a_drv, '1);
        chk("R10 b unchanged", b_out, 18'h22222);
        ba_set(0, 0, 0, 18'h35555);
        tick();
        chk("R5 ba hold", a_out, 18'h0AAAA);
        ba_set(0, 0, 1, 18'h35555);
        tick();
        chk("R4 ba capture", a_out, 18'h35555);
        chk("R10 b still", b_out, 18'h22222);
        @(negedge clk);
        ba_oe_n = 1'b1;
        #1;
        chk("R2 a released", a_drv, '0);
        chk("R2 a value kept", a_out, 18'h35555);
    endtask

    initial begin
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_transparent();
        t_fall_clk_high();
        t_capture();
        t_fall_clk_low();
        t_inhibit();
        t_simul();
        t_oe();
        t_ba();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule